// File: doc/BRIEF.md
# Pipelined Carry-Save Tree Multiplier

This block multiplies two unsigned operands in a clocked pipeline. Operand `op_b` is the multiplier and operand `op_a` is the multiplicand. The first stage turns every bit of `op_b` into one partial-product row and registers the rows. A row holds `op_a` when its bit is set and zeros when it is clear. Row i is shifted left by i places, with zeros filling the low positions.

A tree of 3:2 carry-save adders then cuts the rows down, with one register level per tree level. Each adder takes three addends and returns a sum word and a carry word. With the default 8-bit operands the row count goes 8, 6, 4, 3, 2. A carry-propagate adder in the final registered stage adds the last two addends into the 16-bit product.

A valid bit runs alongside the data through every stage. A new operand pair can enter on every clock, and every result leaves after the same fixed number of cycles. There is no stall input.

Top module: `wallace_mul_pipe`

## Requirements
- R1: For every sampled pair, `out_prod` equals the unsigned product `op_a * op_b`, taken to its full 16-bit width with no truncation.
- R2: With default widths the latency is six register stages: partial products, four carry-save levels and the final adder. A pair sampled on rising edge k shows on `out_valid`/`out_prod` after rising edge k+5.
- R3: Pairs issued on consecutive clocks with `in_valid` high come out on consecutive clocks, in issue order, each with its own product.
- R4: Reset is synchronous and active high. After any rising edge with `rst` high, `out_valid` is 0 and `out_prod` is 0, and pairs in flight are discarded.
- R5: A zero operand on either side gives a product of 0.
- R6: The all-ones pair 255 * 255 gives 65025 (0xFE01), and 255 times a single set bit 2^i gives 255 shifted left by i.
- R7: Each carry-save level keeps the total of its addends modulo 2^16. The sum of its registered output rows equals the sum of the rows it took in one cycle earlier.
- R8: A cycle with `in_valid` low sends a bubble down the pipe: `out_valid` is low exactly six cycles later, and neighbouring valid results are not disturbed.
- R9: The registered partial-product rows add up to the product of the operands sampled one cycle earlier. Row i carries `op_a` shifted by i when bit i of `op_b` is 1, and carries zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all pipeline stages |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on this cycle is valid |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned; bit i selects row i |
| out_valid | output | 1 | Registered result is valid |
| out_prod | output | 16 | Registered unsigned product |

## Verification
Some properties are checked on every cycle. Each stage passes its valid bit on by exactly one cycle. The partial-product rows add up to the product of the previous operands. Every carry-save level keeps the total of its addends, and the output is clear after a reset edge. Other behaviours show only in the bench's scenarios, where a behavioural delay-queue model is compared with the output on every clock: the end-to-end latency, ordering under back-to-back issue, bubbles, the zero and all-ones corners, and the discarding of work in flight when reset arrives mid-stream.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  // Row count after one 3:2 level: every full triple becomes two rows,
  // leftover rows pass straight through.
  function automatic int rows_after(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Row count entering reduction level lvl, starting from npp rows.
  function automatic int rows_at(input int npp, input int lvl);
    int n;
    n = npp;
    for (int k = 0; k < lvl; k++) n = rows_after(n);
    return n;
  endfunction

  // Number of 3:2 levels needed to reach two addends.
  function automatic int num_levels(input int npp);
    int n;
    int l;
    n = npp;
    l = 0;
    while (n > 2) begin
      n = rows_after(n);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/wmul_pp_stage.sv
module wmul_pp_stage #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int PW = AW + BW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_i,
  input  logic [AW-1:0]          mcand_i,
  input  logic [BW-1:0]          mplier_i,
  output logic                   vld_o,
  output logic [BW-1:0][PW-1:0]  rows_o
);

  logic [PW-1:0]          mcand_ext;
  logic [BW-1:0][PW-1:0]  rows_nxt;

  assign mcand_ext = {{(PW-AW){1'b0}}, mcand_i};

  for (genvar i = 0; i < BW; i++) begin : g_row
    assign rows_nxt[i] = mplier_i[i] ? (mcand_ext << i) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      rows_o <= '0;
    end else begin
      vld_o  <= vld_i;
      rows_o <= rows_nxt;
    end
  end

  function automatic logic [PW-1:0] total(input logic [BW-1:0][PW-1:0] r);
    logic [PW-1:0] s;
    s = '0;
    for (int k = 0; k < BW; k++) s = s + r[k];
    return s;
  endfunction

  // R9
  pp_sum_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (total(rows_o) ==
      (PW'($past(mcand_i)) * PW'($past(mplier_i)))));

  // R2
  pp_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/wmul_csa_level.sv
module wmul_csa_level #(
  parameter int PW    = 16,
  parameter int N_IN  = 8,
  parameter int N_OUT = 2 * (N_IN / 3) + (N_IN % 3)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_i,
  input  logic [N_IN-1:0][PW-1:0]  rows_i,
  output logic                     vld_o,
  output logic [N_OUT-1:0][PW-1:0] rows_o
);

  localparam int GRP = N_IN / 3;
  localparam int REM = N_IN % 3;

  logic [N_OUT-1:0][PW-1:0] rows_nxt;

  for (genvar g = 0; g < GRP; g++) begin : g_csa
    logic [PW-1:0] x, y, z;
    logic [PW-2:0] maj;
    assign x = rows_i[3*g];
    assign y = rows_i[3*g+1];
    assign z = rows_i[3*g+2];
    assign maj = (x[PW-2:0] & y[PW-2:0]) | (x[PW-2:0] & z[PW-2:0]) |
                 (y[PW-2:0] & z[PW-2:0]);
    assign rows_nxt[2*g]   = x ^ y ^ z;
    assign rows_nxt[2*g+1] = {maj, 1'b0};
  end

  for (genvar r = 0; r < REM; r++) begin : g_pass
    assign rows_nxt[2*GRP+r] = rows_i[3*GRP+r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      rows_o <= '0;
    end else begin
      vld_o  <= vld_i;
      rows_o <= rows_nxt;
    end
  end

  function automatic logic [PW-1:0] sum_in(input logic [N_IN-1:0][PW-1:0] r);
    logic [PW-1:0] s;
    s = '0;
    for (int k = 0; k < N_IN; k++) s = s + r[k];
    return s;
  endfunction

  function automatic logic [PW-1:0] sum_out(input logic [N_OUT-1:0][PW-1:0] r);
    logic [PW-1:0] s;
    s = '0;
    for (int k = 0; k < N_OUT; k++) s = s + r[k];
    return s;
  endfunction

  // R7
  csa_sum_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sum_out(rows_o) == $past(sum_in(rows_i))));

  // R2
  csa_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/wmul_cpa_stage.sv
module wmul_cpa_stage #(
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic [1:0][PW-1:0]   rows_i,
  output logic                 vld_o,
  output logic [PW-1:0]        prod_o
);

  logic [PW-1:0] add_nxt;

  assign add_nxt = rows_i[0] + rows_i[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      prod_o <= '0;
    end else begin
      vld_o  <= vld_i;
      prod_o <= add_nxt;
    end
  end

  // R4
  cpa_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vld_o && (prod_o == '0)));

  // R2
  cpa_vld_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/wallace_mul_pipe.sv
module wallace_mul_pipe #(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [A_W-1:0]       op_a,
  input  logic [B_W-1:0]       op_b,
  output logic                 out_valid,
  output logic [A_W+B_W-1:0]   out_prod
);

  localparam int PW   = A_W + B_W;
  localparam int NPP  = B_W;
  localparam int NLVL = wmul_pkg::num_levels(NPP);

  logic                   pp_vld;
  logic [NPP-1:0][PW-1:0] pp_rows;

  wmul_pp_stage #(.AW(A_W), .BW(B_W), .PW(PW)) u_pp (
    .clk      (clk),
    .rst      (rst),
    .vld_i    (in_valid),
    .mcand_i  (op_a),
    .mplier_i (op_b),
    .vld_o    (pp_vld),
    .rows_o   (pp_rows)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int NI = wmul_pkg::rows_at(NPP, l);
    localparam int NO = wmul_pkg::rows_after(NI);
    logic                  vld;
    logic [NO-1:0][PW-1:0] rows;
    if (l == 0) begin : g_first
      wmul_csa_level #(.PW(PW), .N_IN(NI), .N_OUT(NO)) u_csa (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (pp_vld),
        .rows_i (pp_rows),
        .vld_o  (vld),
        .rows_o (rows)
      );
    end else begin : g_next
      wmul_csa_level #(.PW(PW), .N_IN(NI), .N_OUT(NO)) u_csa (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (g_lvl[l-1].vld),
        .rows_i (g_lvl[l-1].rows),
        .vld_o  (vld),
        .rows_o (rows)
      );
    end
  end

  wmul_cpa_stage #(.PW(PW)) u_cpa (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (g_lvl[NLVL-1].vld),
    .rows_i (g_lvl[NLVL-1].rows),
    .vld_o  (out_valid),
    .prod_o (out_prod)
  );

endmodule

// File: tb/wallace_mul_pipe_bench.sv
module wallace_mul_pipe_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 6;

  typedef struct {
    bit          v;
    logic [15:0] p;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic        out_valid;
  logic [15:0] out_prod;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  exp_t  q[$];
  exp_t  exp_now;

  wallace_mul_pipe u_wallace_mul_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model: a delay queue of expected results.
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      q.delete();
      for (int k = 0; k < LAT - 1; k++) begin
        e.v = 1'b0; e.p = 16'd0; e.tag = "R4";
        q.push_back(e);
      end
      exp_now.v = 1'b0; exp_now.p = 16'd0; exp_now.tag = "R4";
    end else begin
      e.v   = in_valid;
      e.p   = 16'(op_a) * 16'(op_b);
      e.tag = cur_tag;
      q.push_back(e);
      exp_now = q.pop_front();
    end
  end

  task automatic compare();
    checks++;
    if (out_valid !== exp_now.v) begin
      errors++;
      $display("FAIL R2/%s out_valid actual=%0b expected=%0b", exp_now.tag,
               out_valid, exp_now.v);
    end
    checks++;
    if (out_prod !== exp_now.p) begin
      errors++;
      $display("FAIL %s out_prod actual=%0d expected=%0d", exp_now.tag,
               out_prod, exp_now.p);
    end
  endtask

  task automatic step(input bit v, input logic [7:0] a, input logic [7:0] b,
                      input string tag);
    @(negedge clk);
    compare();
    in_valid = v;
    op_a     = a;
    op_b     = b;
    cur_tag  = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 8'd0, 8'd0, tag);
  endtask

  initial begin
    // R4: reset state
    rst = 1'b1;
    repeat (3) step(1'b0, 8'd0, 8'd0, "R4");
    @(negedge clk);
    compare();
    rst = 1'b0;

    // R5: zero operands
    step(1'b1, 8'd0,   8'd0,   "R5");
    step(1'b1, 8'd0,   8'd255, "R5");
    step(1'b1, 8'd173, 8'd0,   "R5");
    // R6: all ones and single-bit multipliers
    step(1'b1, 8'd255, 8'd255, "R6");
    for (int i = 0; i < 8; i++) step(1'b1, 8'd255, 8'(1 << i), "R6");
    step(1'b1, 8'd1, 8'd255, "R6");
    idle(LAT + 1, "R2");

    // R2: single isolated pair then bubbles
    step(1'b1, 8'd12, 8'd13, "R2");
    idle(LAT + 1, "R2");

    // R3: back-to-back random pairs
    for (int k = 0; k < 120; k++)
      step(1'b1, 8'($urandom), 8'($urandom), "R3");

    // R8: bubbles mixed with valid pairs
    for (int k = 0; k < 60; k++)
      step(k[0], 8'($urandom), 8'($urandom), "R8");

    // R1: random mix, valid low one cycle in four
    for (int k = 0; k < 80; k++)
      step((k % 4) != 3, 8'($urandom), 8'($urandom), "R1");

    // R4: reset with pairs in flight
    for (int k = 0; k < 3; k++) step(1'b1, 8'(200 + k), 8'(50 + k), "R4");
    @(negedge clk);
    compare();
    rst = 1'b1;
    in_valid = 1'b1; op_a = 8'd99; op_b = 8'd77;
    repeat (2) begin @(negedge clk); compare(); end
    rst = 1'b0;
    in_valid = 1'b0;
    cur_tag = "R4";
    idle(LAT + 2, "R4");

    // R1: post-reset operation
    for (int k = 0; k < 20; k++)
      step(1'b1, 8'($urandom), 8'($urandom), "R1");
    idle(LAT + 1, "R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule